// File: doc/BRIEF.md
# Run-Length Bit Expander

This block turns a stream of one-byte run-length codes into a serial stream of single bits. Code bytes arrive on a valid/ready byte port. Each accepted code expands into a run of identical bits. Depending on the code's class, the run may be followed by one terminating bit of the opposite value. Expanded bits leave one per handshake on a valid/ready bit port, and the block holds its output for as long as the consumer stalls.

The code space is split by one parameter, `ONES_MAX`, the longest run of ones that ends in a zero. The other class boundaries are derived from it:

- The code just above `ONES_MAX` gives an unterminated ones run.
- Codes from `ONES_MAX+2` up to one below the all-ones code give zero runs ended by a one.
- The all-ones code gives a single one.
- Code zero is swallowed with no output.

The block accepts a new code only once the previous expansion has been fully handed off.

Top module: `rle_bit_expander`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: A code n with 1 <= n <= 226 produces n bits of value 1, then one bit of value 0.
- R3: Code 227 produces 226 bits of value 1 and no terminating 0.
- R4: A code n with 228 <= n <= 254 produces n-228 bits of value 0, then one bit of value 1. Code 228 therefore produces a lone 1, and code 229 produces 0 then 1.
- R5: Code 255 produces a single bit of value 1.
- R6: Code 0 produces no bits. In the cycle after it is accepted, `inReady` is 1 and `outValid` is 0.
- R7: `inReady` is 0 from the cycle after a code producing bits is accepted until the cycle after its last bit is handed off, when it returns to 1. Bits appear from the cycle after acceptance.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outBit` keeps its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A code byte is offered |
| inByte | input | 8 | Run-length code |
| inReady | output | 1 | The block can take a code |
| outValid | output | 1 | An expanded bit is offered |
| outBit | output | 1 | Expanded bit value |
| outReady | input | 1 | The consumer takes the offered bit |

## Verification
Two events can fall in the same cycle: a consumer stall, and the step in which the run counter reaches its last bit and the output switches to the terminator or back to idle. The bench provokes this by toggling `outReady` at random over codes of every class, including runs of length zero and one. On every cycle it compares the bit value, the valid flag and the input readiness against a queue-based model. Any slip, such as a lost terminator, a doubled bit, or readiness returning a cycle early, shows up as a mismatch against the model's next queued bit.

// File: rtl/rle_exp_pkg.sv
package rle_exp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture the decoded code
    logic step;     // one run bit handed off
    logic selTerm;  // drive the terminator bit
  } rleStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TERM = 2'd2
  } rleState_t;
endpackage

// File: rtl/rle_exp_dp.sv
module rle_exp_dp
  import rle_exp_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int ONES_MAX = 226
) (
  input  logic              clk,
  input  logic              rstN,
  input  rleStrobe_t        strobe,
  input  logic [CODE_W-1:0] inByte,
  output logic              decLenZero,
  output logic              decTerm,
  output logic              cntLast,
  output logic              termPend,
  output logic              outBit
);
  localparam logic [CODE_W-1:0] ONES_LIM  = CODE_W'(ONES_MAX);
  localparam logic [CODE_W-1:0] NO_TERM   = CODE_W'(ONES_MAX + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(ONES_MAX + 2);
  localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] decLen;
  logic              decRunBit;
  logic              decTermBit;

  logic [CODE_W-1:0] runCnt;
  logic              runBit;
  logic              termBit;

  // code class decode
  always_comb begin
    decLen     = '0;
    decRunBit  = 1'b1;
    decTerm    = 1'b0;
    decTermBit = 1'b1;
    if (inByte == '0) begin
      decLen = '0;
    end else if (inByte <= ONES_LIM) begin
      decLen     = inByte;
      decTerm    = 1'b1;
      decTermBit = 1'b0;
    end else if (inByte == NO_TERM) begin
      decLen = ONES_LIM;
    end else if (inByte != LAST_CODE) begin
      decLen     = inByte - ZERO_BASE;
      decRunBit  = 1'b0;
      decTerm    = 1'b1;
      decTermBit = 1'b1;
    end else begin
      decTerm    = 1'b1;
      decTermBit = 1'b1;
    end
  end

  assign decLenZero = (decLen == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      runBit   <= 1'b0;
      termBit  <= 1'b0;
      termPend <= 1'b0;
    end else if (strobe.load) begin
      runCnt   <= decLen;
      runBit   <= decRunBit;
      termBit  <= decTermBit;
      termPend <= decTerm;
    end else if (strobe.step) begin
      runCnt <= runCnt - 1'b1;
    end
  end

  assign cntLast = (runCnt == CODE_W'(1));
  assign outBit  = strobe.selTerm ? termBit : runBit;

  // R2
  run_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inByte != '0 && inByte <= ONES_LIM) |=> (runCnt == $past(inByte)));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (runCnt != '0));
endmodule

// File: rtl/rle_exp_ctl.sv
module rle_exp_ctl
  import rle_exp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       decLenZero,
  input  logic       decTerm,
  input  logic       cntLast,
  input  logic       termPend,
  output logic       inReady,
  output logic       outValid,
  output rleStrobe_t strobe
);
  rleState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.load = 1'b1;
          if (!decLenZero)  stateNext = ST_RUN;
          else if (decTerm) stateNext = ST_TERM;
        end
      end
      ST_RUN: begin
        outValid = 1'b1;
        if (outReady) begin
          strobe.step = 1'b1;
          if (cntLast) stateNext = termPend ? ST_TERM : ST_IDLE;
        end
      end
      ST_TERM: begin
        outValid       = 1'b1;
        strobe.selTerm = 1'b1;
        if (outReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R7
  term_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selTerm && outReady) |=> (inReady && !outValid));
  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !cntLast) |=> (outValid && !inReady));
endmodule

// File: rtl/rle_bit_expander.sv
module rle_bit_expander
  import rle_exp_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int ONES_MAX = 226
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inByte,
  output logic              inReady,
  output logic              outValid,
  output logic              outBit,
  input  logic              outReady
);
  localparam logic [CODE_W-1:0] NO_TERM   = CODE_W'(ONES_MAX + 1);
  localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(ONES_MAX + 2);

  rleStrobe_t strobe;
  logic decLenZero, decTerm, cntLast, termPend;

  rle_exp_ctl ctl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .decLenZero(decLenZero), .decTerm(decTerm), .cntLast(cntLast),
    .termPend(termPend), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  rle_exp_dp #(.CODE_W(CODE_W), .ONES_MAX(ONES_MAX)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte),
    .decLenZero(decLenZero), .decTerm(decTerm), .cntLast(cntLast),
    .termPend(termPend), .outBit(outBit)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBit)));
  // R6
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inByte == '0) |=> (inReady && !outValid));
  // R5
  single_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inByte == {CODE_W{1'b1}}) |=> (outValid && outBit));
  // R4
  zero_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inByte == ZERO_BASE) |=> (outValid && outBit));
  // R3
  no_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inByte == NO_TERM) |=> (outValid && outBit));
endmodule

// File: tb/rle_bit_expander_tb_top.sv
`timescale 1ns/1ps
module rle_bit_expander_tb_top;
  localparam int ONES_MAX = 226;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, inValid, inReady, outValid, outBit, outReady;
  logic [7:0] inByte;

  rle_bit_expander #(.CODE_W(8), .ONES_MAX(ONES_MAX)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inReady(inReady), .outValid(outValid), .outBit(outBit), .outReady(outReady)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    expQ[$];
  int    codes[$];
  string curTag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void expand(input int b);
    if (b >= 1 && b <= ONES_MAX) begin
      for (int k = 0; k < b; k++) expQ.push_back(1'b1);
      expQ.push_back(1'b0);
    end else if (b == ONES_MAX + 1) begin
      for (int k = 0; k < ONES_MAX; k++) expQ.push_back(1'b1);
    end else if (b >= ONES_MAX + 2 && b <= 254) begin
      for (int k = 0; k < b - (ONES_MAX + 2); k++) expQ.push_back(1'b0);
      expQ.push_back(1'b1);
    end else if (b == 255) begin
      expQ.push_back(1'b1);
    end
  endfunction

  function automatic string tagOf(input int b);
    if (b == 0) return "R6";
    if (b <= ONES_MAX) return "R2";
    if (b == ONES_MAX + 1) return "R3";
    if (b <= 254) return "R4";
    return "R5";
  endfunction

  initial begin
    int  cyc;
    int  idx;
    bit  expInR, expOV, lastStall, inFire, outFire;
    rstN = 1'b0; inValid = 1'b0; inByte = '0; outReady = 1'b0;
    lastStall = 1'b0;

    // directed codes covering every class and its edges
    codes = '{0, 1, 2, 5, 226, 227, 228, 229, 230, 254, 255, 0, 0, 3, 255, 228};
    for (int k = 0; k < 40; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5)      codes.push_back($urandom_range(0, 12));
      else if (r < 7) codes.push_back($urandom_range(228, 240));
      else            codes.push_back($urandom_range(0, 255));
    end

    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R1", inReady, 1);
    chk(outValid == 1'b0, "R1", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1", inReady, 1);
    chk(outValid == 1'b0, "R1", outValid, 0);

    cyc = 0;
    idx = 0;
    while ((idx < codes.size() || expQ.size() != 0 || inValid) && cyc < 150000) begin
      // drive the next stimulus, stable across the coming edge
      if (!inValid && idx < codes.size() && $urandom_range(0, 3) != 0) begin
        inValid = 1'b1;
        inByte  = 8'(codes[idx]);
        idx++;
      end
      if (idx <= 16)      outReady = 1'b1;
      else if (idx < 40)  outReady = ($urandom_range(0, 1) == 1);
      else                outReady = ($urandom_range(0, 3) == 0);

      // model: handshakes at the coming edge
      expInR  = (expQ.size() == 0);
      expOV   = !expInR;
      inFire  = inValid && expInR;
      outFire = expOV && outReady;
      lastStall = expOV && !outReady;
      if (outFire) void'(expQ.pop_front());
      if (inFire) begin
        expand(int'(inByte));
        curTag = tagOf(int'(inByte));
      end

      @(negedge clk);
      cyc++;
      if (inFire) inValid = 1'b0;

      // compare against the model after the edge
      expInR = (expQ.size() == 0);
      expOV  = !expInR;
      chk(inReady == expInR, {"R7 ", curTag}, inReady, expInR);
      chk(outValid == expOV, curTag, outValid, expOV);
      if (expOV && outValid)
        chk(outBit == expQ[0], lastStall ? "R8" : curTag, outBit, expQ[0]);
    end

    if (cyc >= 150000) chk(1'b0, "watchdog", cyc, 150000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule